// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers asynchronous character frames from one serial line. It takes a sampling enable that pulses sixteen times per nominal bit period. A falling edge on the idle-high line starts a frame, and each bit is captured once, early in its cell, at the sixth or seventh oversampling tick. The early point is chosen by a configuration input. The frame layout is set by static configuration inputs: five to eight data bits sent least significant bit first, an optional even or odd parity bit, and one or two stop bits. The whole frame is therefore 7 to 12 bits long.

Each completed frame produces a one-cycle valid pulse. The received byte comes with it, together with parity and framing error flags, and these outputs hold until the next frame completes. A loopback select feeds an internal transmit line into the receiver instead of the external pin, so the host-side path can be exercised without wiring. The selected line passes through a two-flop synchronizer before edge detection. The configuration inputs are expected to stay stable while a frame is in progress.

Top module: `uart_os_rx`

## Requirements
- R1: While rst_n is low the receiver returns to hunting for a start edge, and rx_valid, rx_data, rx_perr and rx_ferr are all zero; this also applies to a reset applied in the middle of a frame.
- R2: A bit cell lasts 16 tick16 pulses counted from the detected start edge. Each cell is sampled once, at its 6th tick when cfg_late is 0 and at its 7th tick when cfg_late is 1.
- R3: cfg_wlen selects the number of data bits: 0 for 5, 1 for 6, 2 for 7, 3 for 8. The first data bit received lands in rx_data[0], and rx_data bits at and above the word length read zero.
- R4: When cfg_par_en is 1, one parity bit follows the data. cfg_par_odd is 0 for even parity and 1 for odd parity, counted over the data bits and the parity bit. A mismatch raises rx_perr alongside the byte. When cfg_par_en is 0 there is no parity bit and rx_perr stays 0.
- R5: cfg_stop2 is 0 for one stop bit and 1 for two. A low level at any stop-bit sample raises rx_ferr, and the byte is still delivered.
- R6: If the line reads high at the start-bit sample, the frame is dropped with no rx_valid pulse.
- R7: rx_valid pulses for exactly one cycle after the last stop-bit sample. rx_data and the flags hold until the next frame completes, and a start edge arriving at the end of that stop bit is accepted.
- R8: When lb_en is 1 the receiver reads lb_txd and ignores rxd_pin. When lb_en is 0 it reads rxd_pin and ignores lb_txd.
- R9: Frames are decoded correctly when the far-end bit period is up to 3.2% shorter than nominal for a 12-bit frame and up to 5.8% shorter for a 7-bit frame, at either sample point. They are also decoded correctly when the far-end bit period is that much longer, with cfg_late set to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Sampling enable, 16 pulses per nominal bit |
| rxd_pin | input | 1 | External serial input, idle high |
| lb_txd | input | 1 | Internal transmit serial line used in loopback |
| lb_en | input | 1 | 1 selects lb_txd as the receive source |
| cfg_wlen | input | 2 | Word length code, 0..3 for 5..8 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 for odd parity, 0 for even |
| cfg_stop2 | input | 1 | 1 for two stop bits |
| cfg_late | input | 1 | 1 samples at tick 7, 0 at tick 6 |
| rx_data | output | 8 | Received byte, zero above the word length |
| rx_valid | output | 1 | One-cycle pulse when a frame completes |
| rx_perr | output | 1 | Parity mismatch for the presented byte |
| rx_ferr | output | 1 | Low stop bit seen for the presented byte |

## Verification
Frames are driven at every word length, with and without parity of each sense, and with one or two stop bits. Single-bit corruption of the parity or of a chosen stop bit tells the error flags apart from the data path. A start pulse that is low for 24 clocks, aligned to the tick phase, is accepted with tick-6 sampling and dropped with tick-7 sampling, which separates the two sample points. Frames with a bit period stretched or shrunk to the tolerance corners confirm the timing margin. Loopback frames are sent on either line with the select in both states to show which source is actually heard.

// File: rtl/uart_rx_pkg.sv
`timescale 1ns/1ps
package uart_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;
endpackage

// File: rtl/uart_rx_front.sv
`timescale 1ns/1ps
// Source select, synchronizer and falling-edge detector.
module uart_rx_front #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic lb_line,
  input  logic lb_en,
  output logic line,
  output logic fall
);
  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  // R8 loopback source select ahead of the synchronizer
  always_comb src = lb_en ? lb_line : pin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_comb begin
    line = sync_q[SYNC_STAGES-1];
    fall = prev_q & ~line;
  end
endmodule

// File: rtl/uart_rx_timer.sv
`timescale 1ns/1ps
// Oversampling counter inside one bit cell.
module uart_rx_timer #(
  parameter int OS_RATE   = 16,
  parameter int SMP_EARLY = 6,
  parameter int SMP_LATE  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic run,
  input  logic late,
  output logic smp,
  output logic bit_end
);
  localparam int CW = $clog2(OS_RATE);
  localparam logic [CW-1:0] PT_E = CW'(SMP_EARLY - 1);
  localparam logic [CW-1:0] PT_L = CW'(SMP_LATE - 1);
  localparam logic [CW-1:0] LAST = CW'(OS_RATE - 1);

  logic [CW-1:0] cnt_q, cnt_d, pt;
  logic          cnt_en;

  always_comb begin
    pt      = late ? PT_L : PT_E;
    smp     = run & tick & (cnt_q == pt);
    bit_end = run & tick & (cnt_q == LAST);
    cnt_en  = ~run | tick;
    if (!run)               cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R2
  cell_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && cnt_q == LAST) |=> (cnt_q == '0));
endmodule

// File: rtl/uart_rx_ctrl.sv
`timescale 1ns/1ps
// Frame sequencer, data capture, parity and stop checking.
module uart_rx_ctrl
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line,
  input  logic              fall,
  input  logic              smp,
  input  logic              bit_end,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  output logic              run,
  output logic [DATA_W-1:0] out_data,
  output logic              out_valid,
  output logic              out_perr,
  output logic              out_ferr
);
  localparam int MIN_BITS = DATA_W - 3;
  localparam int IDX_W    = $clog2(DATA_W);

  rx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_idx;
  logic [DATA_W-1:0] shf_q, shf_d, dat_q, dat_d;
  logic              par_q, par_d, perr_q, perr_d, ferr_q, ferr_d;
  logic              stp_q, stp_d;
  logic              vld_q, vld_d, operr_q, operr_d, oferr_q, oferr_d;
  logic              frm_en;

  always_comb begin
    last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_wlen);
    state_d  = state_q;
    idx_d    = idx_q;
    shf_d    = shf_q;
    par_d    = par_q;
    perr_d   = perr_q;
    ferr_d   = ferr_q;
    stp_d    = stp_q;
    dat_d    = dat_q;
    operr_d  = operr_q;
    oferr_d  = oferr_q;
    vld_d    = 1'b0;
    case (state_q)
      ST_IDLE: if (fall) begin
        state_d = ST_START;
        idx_d   = '0;
        shf_d   = '0;
        par_d   = 1'b0;
        perr_d  = 1'b0;
        ferr_d  = 1'b0;
        stp_d   = 1'b0;
      end
      ST_START: begin
        if (smp && line)  state_d = ST_IDLE;
        else if (bit_end) state_d = ST_DATA;
      end
      ST_DATA: begin
        if (smp) begin
          shf_d[idx_q] = line;
          par_d        = par_q ^ line;
        end
        if (bit_end) begin
          if (idx_q == last_idx) state_d = cfg_par_en ? ST_PAR : ST_STOP;
          else                   idx_d   = idx_q + 1'b1;
        end
      end
      ST_PAR: begin
        if (smp)     perr_d  = par_q ^ line ^ cfg_par_odd;
        if (bit_end) state_d = ST_STOP;
      end
      ST_STOP: begin
        if (smp) begin
          if (stp_q == cfg_stop2) begin
            vld_d   = 1'b1;
            dat_d   = shf_q;
            operr_d = perr_q;
            oferr_d = ferr_q | ~line;
            state_d = ST_IDLE;
          end else begin
            ferr_d = ferr_q | ~line;
          end
        end
        if (bit_end) stp_d = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb frm_en = (state_q != ST_IDLE) | fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shf_q   <= '0;
      par_q   <= 1'b0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
      stp_q   <= 1'b0;
      dat_q   <= '0;
      vld_q   <= 1'b0;
      operr_q <= 1'b0;
      oferr_q <= 1'b0;
    end else begin
      state_q <= state_d;
      vld_q   <= vld_d;
      if (frm_en) begin
        idx_q   <= idx_d;
        shf_q   <= shf_d;
        par_q   <= par_d;
        perr_q  <= perr_d;
        ferr_q  <= ferr_d;
        stp_q   <= stp_d;
        dat_q   <= dat_d;
        operr_q <= operr_d;
        oferr_q <= oferr_d;
      end
    end
  end

  always_comb begin
    run       = (state_q != ST_IDLE);
    out_data  = dat_q;
    out_valid = vld_q;
    out_perr  = operr_q;
    out_ferr  = oferr_q;
  end

  logic [IDX_W:0] nbits;
  always_comb nbits = (IDX_W+1)'(MIN_BITS) + (IDX_W+1)'(cfg_wlen);

  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);
  // R7
  valid_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($past(state_q) == ST_STOP));
  // R6
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_START && smp && line) |=> (state_q == ST_IDLE && !vld_q));
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ((dat_q >> nbits) == '0));
  // R4
  no_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !cfg_par_en) |-> !operr_q);
endmodule

// File: rtl/uart_os_rx.sv
`timescale 1ns/1ps
module uart_os_rx #(
  parameter int DATA_W      = 8,
  parameter int OS_RATE     = 16,
  parameter int SMP_EARLY   = 6,
  parameter int SMP_LATE    = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick16,
  input  logic              rxd_pin,
  input  logic              lb_txd,
  input  logic              lb_en,
  input  logic [1:0]        cfg_wlen,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_stop2,
  input  logic              cfg_late,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_perr,
  output logic              rx_ferr
);
  logic line, fall, run, smp, bit_end;

  uart_rx_front #(.SYNC_STAGES(SYNC_STAGES)) u_front (
    .clk(clk), .rst_n(rst_n), .pin(rxd_pin), .lb_line(lb_txd),
    .lb_en(lb_en), .line(line), .fall(fall)
  );

  uart_rx_timer #(.OS_RATE(OS_RATE), .SMP_EARLY(SMP_EARLY), .SMP_LATE(SMP_LATE)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick16), .run(run), .late(cfg_late),
    .smp(smp), .bit_end(bit_end)
  );

  uart_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .line(line), .fall(fall), .smp(smp),
    .bit_end(bit_end), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2), .run(run),
    .out_data(rx_data), .out_valid(rx_valid), .out_perr(rx_perr),
    .out_ferr(rx_ferr)
  );
endmodule

// File: tb/tb_uart_os_rx.sv
`timescale 1ns/1ps
module tb_uart_os_rx;
  localparam int  CLK_NS   = 10;
  localparam int  TICK_DIV = 4;
  localparam real BIT_NS   = 16.0 * TICK_DIV * CLK_NS;
  localparam int  WD_LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n, tick16, rxd_pin, lb_txd, lb_en;
  logic [1:0] cfg_wlen;
  logic cfg_par_en, cfg_par_odd, cfg_stop2, cfg_late;
  logic [7:0] rx_data;
  logic rx_valid, rx_perr, rx_ferr;

  always #(CLK_NS/2) clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv   <= (tdiv + 1) % TICK_DIV;
    tick16 <= (tdiv == TICK_DIV - 1);
  end

  uart_os_rx dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd_pin(rxd_pin),
    .lb_txd(lb_txd), .lb_en(lb_en), .cfg_wlen(cfg_wlen),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .cfg_stop2(cfg_stop2), .cfg_late(cfg_late), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_perr(rx_perr), .rx_ferr(rx_ferr)
  );

  int checks = 0, errors = 0, got_cnt = 0, cyc = 0;
  logic [9:0] exp_q[$];
  string      tag_q[$];
  logic       prev_v = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pop scoreboard entries as frames complete.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (rx_valid && prev_v) chk(1'b0, "R7", "valid wider than one cycle", 2, 1);
      if (rx_valid) begin
        got_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected frame", {rx_perr, rx_ferr, rx_data}, 0);
        end else begin
          logic [9:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk({rx_perr, rx_ferr, rx_data} == e, t, "perr,ferr,data",
              {rx_perr, rx_ferr, rx_data}, e);
        end
      end
      prev_v = rx_valid;
    end else begin
      prev_v = 1'b0;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      chk(1'b0, "WD", "watchdog expired", cyc, WD_LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic drive(input bit via_lb, input logic v);
    if (via_lb) lb_txd = v;
    else        rxd_pin = v;
  endtask

  // Driver: builds one frame from the current configuration, pushes the
  // expected result, then shifts it out with the given bit-period scale.
  task automatic send(input logic [7:0] d, input real scale, input bit via_lb,
                      input bit want, input bit bad_par, input int bad_stop,
                      input string tag);
    int nb;
    logic [7:0] dm;
    logic pbit;
    real bt;
    nb = 5 + int'(cfg_wlen);
    dm = d & (8'hFF >> (8 - nb));
    pbit = (^dm) ^ cfg_par_odd ^ bad_par;
    bt = BIT_NS * scale;
    if (want) begin
      exp_q.push_back({bad_par & cfg_par_en, bad_stop >= 0, dm});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    drive(via_lb, 1'b0); #(bt);
    for (int i = 0; i < nb; i++) begin drive(via_lb, d[i]); #(bt); end
    if (cfg_par_en) begin drive(via_lb, pbit); #(bt); end
    for (int s = 0; s < (cfg_stop2 ? 2 : 1); s++) begin
      drive(via_lb, (s == bad_stop) ? 1'b0 : 1'b1); #(bt);
    end
    drive(via_lb, 1'b1); #(bt * 2);
  endtask

  task automatic set_cfg(input logic [1:0] w, input logic pe, input logic po,
                         input logic s2, input logic lt);
    cfg_wlen = w; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2; cfg_late = lt;
  endtask

  // Start pulse low for 24 clocks, launched one clock after a tick edge.
  task automatic glitch24();
    @(negedge clk);
    while (tdiv != 0) @(negedge clk);
    rxd_pin = 1'b0;
    repeat (24) @(negedge clk);
    rxd_pin = 1'b1;
    #(BIT_NS * 12);
  endtask

  int base;

  initial begin
    rst_n = 1'b0; rxd_pin = 1'b1; lb_txd = 1'b1; lb_en = 1'b0; tick16 = 1'b0;
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rx_valid == 1'b0, "R1", "rx_valid in reset", rx_valid, 0);
    chk(rx_data == 8'h00, "R1", "rx_data in reset", rx_data, 0);
    chk({rx_perr, rx_ferr} == 2'b00, "R1", "flags in reset", {rx_perr, rx_ferr}, 0);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);

    // R3 word lengths, LSB first, upper bits zero
    send(8'hA5, 1.0, 0, 1, 0, -1, "R3");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0); send(8'hFF, 1.0, 0, 1, 0, -1, "R3");
    set_cfg(2'd1, 1'b0, 1'b0, 1'b0, 1'b1); send(8'h96, 1.0, 0, 1, 0, -1, "R3");
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0, 1'b0); send(8'h81, 1.0, 0, 1, 0, -1, "R3");
    // R4 parity, even and odd, good and bad
    set_cfg(2'd2, 1'b1, 1'b0, 1'b0, 1'b0); send(8'h5A, 1.0, 0, 1, 0, -1, "R4");
    send(8'h5A, 1.0, 0, 1, 1, -1, "R4");
    set_cfg(2'd3, 1'b1, 1'b1, 1'b0, 1'b1); send(8'h37, 1.0, 0, 1, 0, -1, "R4");
    send(8'h00, 1.0, 0, 1, 1, -1, "R4");
    // R5 stop bits and framing errors
    set_cfg(2'd3, 1'b0, 1'b0, 1'b1, 1'b0); send(8'hC3, 1.0, 0, 1, 0, -1, "R5");
    send(8'h3C, 1.0, 0, 1, 0, 1, "R5");
    send(8'h71, 1.0, 0, 1, 0, 0, "R5");
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0, 1'b0); send(8'hE4, 1.0, 0, 1, 1, 0, "R5");
    // R7 back-to-back frames and held outputs
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_q.push_back({2'b00, 8'h11}); tag_q.push_back("R7");
    exp_q.push_back({2'b00, 8'hEE}); tag_q.push_back("R7");
    @(negedge clk);
    for (int f = 0; f < 2; f++) begin
      logic [7:0] v;
      v = (f == 0) ? 8'h11 : 8'hEE;
      rxd_pin = 1'b0; #(BIT_NS);
      for (int i = 0; i < 8; i++) begin rxd_pin = v[i]; #(BIT_NS); end
      rxd_pin = 1'b1; #(BIT_NS);
    end
    #(BIT_NS * 3);
    chk(rx_data == 8'hEE, "R7", "data held after frame", rx_data, 8'hEE);

    // R6 / R2 start pulse of 24 clocks: accepted at tick 6, dropped at tick 7
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_q.push_back({2'b00, 8'hFF}); tag_q.push_back("R2");
    glitch24();
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b1);
    base = got_cnt;
    glitch24();
    chk(got_cnt == base, "R6", "glitch produced frame", got_cnt, base);
    send(8'h42, 1.0, 0, 1, 0, -1, "R6");

    // R8 loopback
    rxd_pin = 1'b1; lb_txd = 1'b1; lb_en = 1'b1;
    repeat (4) @(negedge clk);
    rxd_pin = 1'b0;
    send(8'h9D, 1.0, 1, 1, 0, -1, "R8");
    rxd_pin = 1'b1;
    repeat (4) @(negedge clk);
    lb_en = 1'b0;
    repeat (4) @(negedge clk);
    base = got_cnt;
    send(8'h55, 1.0, 1, 0, 0, -1, "R8");
    chk(got_cnt == base, "R8", "lb_txd heard with lb_en=0", got_cnt, base);
    send(8'h66, 1.0, 0, 1, 0, -1, "R8");

    // R9 rate tolerance corners
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1, 1'b0);
    send(8'hB6, 0.968, 0, 1, 0, -1, "R9");
    set_cfg(2'd3, 1'b1, 1'b0, 1'b1, 1'b1);
    send(8'h6B, 0.968, 0, 1, 0, -1, "R9");
    send(8'hD9, 1.032, 0, 1, 0, -1, "R9");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h15, 0.942, 0, 1, 0, -1, "R9");
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    send(8'h0A, 0.942, 0, 1, 0, -1, "R9");
    send(8'h1B, 1.058, 0, 1, 0, -1, "R9");

    // R1 reset in the middle of a frame
    set_cfg(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rxd_pin = 1'b0;
    repeat (200) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(rx_data == 8'h00, "R1", "rx_data after mid-frame reset", rx_data, 0);
    chk({rx_valid, rx_perr, rx_ferr} == 3'b000, "R1", "valid/flags after mid-frame reset",
        {rx_valid, rx_perr, rx_ferr}, 0);
    rxd_pin = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(8'h3E, 1.0, 0, 1, 0, -1, "R1");

    #(BIT_NS * 3);
    chk(exp_q.size() == 0, "R7", "frames still outstanding", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule